// File: doc/BRIEF.md
# Serial DAC Command Receiver

This block is the digital input stage of a serial-programmed voltage DAC. A host writes to it over a three-wire link: an active-low frame select, a serial clock and a data line. Each write is a 24-bit word. The receiver samples the data line on every falling edge of the serial clock and collects the bits in a shift register. The command takes effect on the 24th falling edge, without waiting for frame select to return high. The result is a 16-bit straight-binary DAC code, with the ideal output proportional to code/65536, and a 2-bit power-mode field.

The serial lines are asynchronous to the system clock. They are oversampled by a system clock that runs at least four times faster than the serial clock, through two-flop synchronizers and edge detectors. Every committed frame raises a one-cycle update strobe together with the new register values. A frame that ends early is thrown away. Clock edges that arrive after a frame has committed are ignored until frame select has gone high and then low again.

Top module: `dac_serial_rx`

## Requirements
- R1: After reset, `dac_code` is 0, `pwr_mode` is 2'b00 (normal operation) and `upd_strobe` is 0.
- R2: A frame starts when `sel_n` falls. `sdi` is sampled on each falling edge of `sck`, MSB first. On commit, `dac_code` takes word bits 15:0 as a straight-binary value from 0 to 65535.
- R3: On commit, `pwr_mode` takes word bits 17:16, where 2'b00 means normal operation.
- R4: Word bits 23:18 have no effect on any output.
- R5: With `sel_n` still low, the outputs show the new command no later than 8 system clocks after the 24th falling `sck` edge.
- R6: Each committed frame raises `upd_strobe` for exactly one system clock, in the same cycle the new values appear. No other event raises it.
- R7: If `sel_n` rises before the 24th falling edge, the partial frame is discarded. The outputs keep their values and no strobe is raised.
- R8: `sck` edges after the 24th and before `sel_n` rises change nothing. A new frame needs `sel_n` to go high and then low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Active-low frame select (asynchronous) |
| sck | input | 1 | Serial clock; data sampled on its falling edge |
| sdi | input | 1 | Serial data, MSB first |
| dac_code | output | 16 | Straight-binary DAC code |
| pwr_mode | output | 2 | Power-mode field, 00 = normal |
| upd_strobe | output | 1 | One-cycle pulse per committed frame |

## Verification
Complete frames are sent with the extreme codes, with every mode value and with all don't-care bits set. This separates the code field from the mode field and shows that the high bits are dropped. A frame cut one bit short and a frame followed by a second burst of 24 edges under the same select show that partial frames are discarded and that late edges are ignored. Frames drawn at random, some of them truncated to random lengths, are checked against a model in the bench. The outputs and the strobe count are sampled while select is still low, which confirms that the commit does not wait for select to rise.

// File: rtl/dac_rx_pkg.sv
package dac_rx_pkg;
  localparam int FRAME_BITS = 24;
  localparam int CODE_W     = 16;
  localparam int MODE_W     = 2;
  localparam int KEEP_W     = CODE_W + MODE_W;
  localparam logic [MODE_W-1:0] MODE_NORMAL = '0;
endpackage

// File: rtl/dac_rx_sync.sv
module dac_rx_sync #(
  parameter int          WIDTH   = 3,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= RST_VAL;
        else if (s == 0) stage_q[s] <= din;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/dac_rx_frame.sv
module dac_rx_frame
  import dac_rx_pkg::*;
#(
  parameter int NBITS = FRAME_BITS,
  parameter int KW    = KEEP_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel_n_s,
  input  logic          sck_s,
  input  logic          sdi_s,
  output logic          done,
  output logic [KW-1:0] word
);
  localparam int CNT_W = $clog2(NBITS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NBITS - 1);

  logic             sel_q, sck_q, active;
  logic [CNT_W-1:0] cnt;
  logic [KW-1:0]    shreg;
  logic             sel_fall, sck_fall;

  assign sel_fall = sel_q & ~sel_n_s;
  assign sck_fall = sck_q & ~sck_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= 1'b1;
      sck_q  <= 1'b0;
      active <= 1'b0;
      cnt    <= '0;
      shreg  <= '0;
      done   <= 1'b0;
    end else begin
      sel_q <= sel_n_s;
      sck_q <= sck_s;
      done  <= 1'b0;
      if (sel_n_s) begin
        active <= 1'b0;
        cnt    <= '0;
      end else if (sel_fall) begin
        active <= 1'b1;
        cnt    <= '0;
      end else if (active && sck_fall) begin
        shreg <= {shreg[KW-2:0], sdi_s};
        if (cnt == LAST) begin
          done   <= 1'b1;
          active <= 1'b0;
          cnt    <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign word = shreg;

  logic chk_armed;
  always_ff @(posedge clk) chk_armed <= !rst;

  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (rst || !chk_armed)
    cnt <= LAST);
  assert_done_single_R6: assert property (@(posedge clk) disable iff (rst || !chk_armed)
    done |=> !done);
  assert_abort_R7: assert property (@(posedge clk) disable iff (rst || !chk_armed)
    sel_n_s |=> !active && !done);
  assert_no_rearm_R8: assert property (@(posedge clk) disable iff (rst || !chk_armed)
    done |-> !active);
endmodule

// File: rtl/dac_rx_cmd.sv
module dac_rx_cmd
  import dac_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [KEEP_W-1:0] word,
  output logic [CODE_W-1:0] code,
  output logic [MODE_W-1:0] mode,
  output logic              strobe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      code   <= '0;
      mode   <= MODE_NORMAL;
      strobe <= 1'b0;
    end else begin
      strobe <= load;
      if (load) begin
        code <= word[CODE_W-1:0];
        mode <= word[KEEP_W-1:CODE_W];
      end
    end
  end

  logic chk_armed;
  always_ff @(posedge clk) chk_armed <= !rst;

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst || !chk_armed)
    !strobe |-> ($stable(code) && $stable(mode)));
  assert_strobe_src_R6: assert property (@(posedge clk) disable iff (rst || !chk_armed)
    strobe |-> $past(load));
endmodule

// File: rtl/dac_serial_rx.sv
module dac_serial_rx
  import dac_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_n,
  input  logic              sck,
  input  logic              sdi,
  output logic [CODE_W-1:0] dac_code,
  output logic [MODE_W-1:0] pwr_mode,
  output logic              upd_strobe
);
  logic [2:0]        raw_in, syn_in;
  logic              frame_done;
  logic [KEEP_W-1:0] frame_word;

  assign raw_in = {sel_n, sck, sdi};

  dac_rx_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (raw_in),
    .dout (syn_in)
  );

  dac_rx_frame #(.NBITS(FRAME_BITS), .KW(KEEP_W)) u_frame (
    .clk     (clk),
    .rst     (rst),
    .sel_n_s (syn_in[2]),
    .sck_s   (syn_in[1]),
    .sdi_s   (syn_in[0]),
    .done    (frame_done),
    .word    (frame_word)
  );

  dac_rx_cmd u_cmd (
    .clk    (clk),
    .rst    (rst),
    .load   (frame_done),
    .word   (frame_word),
    .code   (dac_code),
    .mode   (pwr_mode),
    .strobe (upd_strobe)
  );
endmodule

// File: tb/dac_serial_rx_test.sv
module dac_serial_rx_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sel_n = 1'b1;
  logic        sck = 1'b0;
  logic        sdi = 1'b0;
  logic [15:0] dac_code;
  logic [1:0]  pwr_mode;
  logic        upd_strobe;

  int errors = 0;
  int checks = 0;
  int strobes = 0;
  logic prev_strobe = 1'b0;
  logic [15:0] m_code = 16'h0;
  logic [1:0]  m_mode = 2'b00;

  always #2.5 clk = ~clk;

  dac_serial_rx uut (
    .clk(clk), .rst(rst), .sel_n(sel_n), .sck(sck), .sdi(sdi),
    .dac_code(dac_code), .pwr_mode(pwr_mode), .upd_strobe(upd_strobe)
  );

  function automatic logic [15:0] f_code(input logic [23:0] w);
    return w[15:0];
  endfunction
  function automatic logic [1:0] f_mode(input logic [23:0] w);
    return w[17:16];
  endfunction

  always @(posedge clk) begin
    if (!rst) begin
      if (upd_strobe) strobes++;
      if (prev_strobe && upd_strobe) begin
        errors++;
        $display("FAIL R6 strobe wide: actual=2+ cycles expected=1");
      end
      prev_strobe <= upd_strobe;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic start_frame();
    sel_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_bits(input logic [23:0] w, input int n);
    for (int i = 0; i < n; i++) begin
      sck = 1'b1;
      sdi = w[23-i];
      repeat (4) @(negedge clk);
      sck = 1'b0;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic end_frame();
    repeat (2) @(negedge clk);
    sel_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic full_frame(input logic [23:0] w, input string tag);
    int s0;
    s0 = strobes;
    start_frame();
    send_bits(w, 24);
    repeat (8) @(negedge clk);
    m_code = f_code(w);
    m_mode = f_mode(w);
    check({tag, " R2/R5 code"}, 32'(dac_code), 32'(m_code));
    check({tag, " R3 mode"}, 32'(pwr_mode), 32'(m_mode));
    check({tag, " R6 strobe count"}, 32'(strobes - s0), 32'd1);
    end_frame();
  endtask

  task automatic short_frame(input logic [23:0] w, input int n);
    int s0;
    s0 = strobes;
    start_frame();
    send_bits(w, n);
    end_frame();
    check("R7 code kept", 32'(dac_code), 32'(m_code));
    check("R7 mode kept", 32'(pwr_mode), 32'(m_mode));
    check("R7 no strobe", 32'(strobes - s0), 32'd0);
  endtask

  initial begin
    int s0;
    void'($urandom(32'h5eed_1234));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 code", 32'(dac_code), 32'h0);
    check("R1 mode", 32'(pwr_mode), 32'h0);
    check("R1 strobe", 32'(upd_strobe), 32'h0);

    full_frame(24'h00FFFF, "max");
    full_frame(24'h000000, "zero");
    full_frame(24'h021234, "mode2");
    full_frame(24'h030000, "mode3");
    full_frame(24'hFC8001, "R4 dontcare");
    full_frame(24'hFD7FFE, "R4 dontcare2");

    short_frame(24'h00ABCD, 23);
    short_frame(24'h03FFFF, 1);

    s0 = strobes;
    start_frame();
    send_bits(24'h015555, 24);
    send_bits(24'h02AAAA, 24);
    repeat (8) @(negedge clk);
    m_code = 16'h5555;
    m_mode = 2'b01;
    check("R8 code", 32'(dac_code), 32'h5555);
    check("R8 mode", 32'(pwr_mode), 32'h1);
    check("R8 strobe count", 32'(strobes - s0), 32'd1);
    end_frame();
    full_frame(24'h00C3C3, "R8 next frame");

    for (int k = 0; k < 20; k++) begin
      logic [23:0] w;
      int n;
      w = 24'($urandom);
      n = (($urandom % 4) == 0) ? int'(1 + ($urandom % 23)) : 24;
      if (n == 24) full_frame(w, "rand");
      else short_frame(w, n);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule